// File: doc/BRIEF.md
# SPI Pipelined Command Decoder

This block is the serial slave front end of a position sensor. A host sends fixed 32-bit command frames over a four-wire serial link (clock idle low, data sampled on the rising clock edge, most significant bit first). The top byte of each frame is a control byte that selects one of four write actions and one of four read sources. The low 24 bits are the payload. The write actions are: nothing, an immediate load of the 14-bit multi-cycle counter, a deferred (atomic) counter load, or a write to a small byte-wide register file.

Responses trail their commands by one frame. The read source named in frame N is sampled when slave select falls for frame N+1, and it is shifted out during that frame. The atomic write mode holds its counter value in a pending register and loads it at the next slave-select falling edge. That is the same instant the next response snapshot is taken, so the host sees the newly loaded count beside a position taken at that same moment. Position, status and ADC values come from the interpolator as plain inputs. All serial pins are synchronised into the system clock domain.

Top module: `spi_cmd_pipe`

## Requirements
- R1: A frame is the span of `spi_cs_n` low. Data is taken on rising `spi_sclk` and shifted out on falling `spi_sclk`, MSB first. Bits 31:30 are the write mode and bits 29:28 are the read mode.
- R2: The response to a frame's read mode is captured at the next falling edge of `spi_cs_n` and shifted out during that next frame. `spi_miso` is 0 while `spi_cs_n` is high.
- R3: Read mode 0 returns {counter[13:0], pos_live[9:0], stat_live[7:0]}.
- R4: Read mode 1 returns {counter[13:0], pos_held[9:0], stat_held[7:0]}.
- R5: Read mode 2 returns {adc_sin[9:0], adc_cos[9:0], adc_zero[9:0], 2'b00}.
- R6: Read mode 3 returns {addr[7:0], data[7:0], 6'b0, pos_live[9:0]}, where addr is bits 23:16 of the requesting frame. An address of 8 or more reads as data 0.
- R7: Write mode 1 loads the counter from bits 14:1 and `mc_sync` from bit 0 once the frame completes.
- R8: Write mode 2 leaves the counter unchanged at frame end. It loads the held value at the next falling edge of `spi_cs_n`, and that frame's response already shows the loaded count.
- R9: A counter write (mode 1 or 2) is discarded if any of bits 23:15 is nonzero. Any write is discarded if any of control bits 27:24 is nonzero.
- R10: Write mode 3 writes bits 7:0 to the register at address bits 23:16 (addresses 0 to 7). Write mode 0 changes nothing, whatever its payload.
- R11: A frame with other than 32 rising clock edges makes no write and leaves the stored read selection unchanged. It sets `frame_err`, which the next 32-edge frame clears.
- R12: After reset the counter, `mc_sync`, `mc_load`, `frame_err` and `spi_miso` are 0, and the read selection is mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Slave select, active low |
| spi_mosi | input | 1 | Serial command data |
| spi_miso | output | 1 | Serial response data |
| pos_live | input | 10 | Current position |
| stat_live | input | 8 | Current status |
| pos_held | input | 10 | Externally captured position |
| stat_held | input | 8 | Externally captured status |
| adc_sin | input | 10 | Sine channel sample |
| adc_cos | input | 10 | Cosine channel sample |
| adc_zero | input | 10 | Zero channel sample |
| mc_value | output | 14 | Multi-cycle counter value |
| mc_sync | output | 1 | Synchronisation flag of the last counter load |
| mc_load | output | 1 | One-cycle pulse on each counter load |
| frame_err | output | 1 | Last frame had a wrong bit count |

## Verification
The hardest case to reach is the atomic load. The bench has to show that the counter holds its old value across the end of the writing frame, then changes exactly at the following select edge, and that the response captured at that edge carries the new count rather than the old one. The bench sends the atomic frame, checks the counter after select rises, and then runs a no-op frame whose shifted-out counter field must equal the pending value. A bad-length frame wedged between a read request and its response frame checks that the stored selection survives the discard.

// File: rtl/spi_cmd_pkg.sv
// Package: shared command encodings for the serial command decoder.
// Assumes the write and read mode fields are two bits each.
package spi_cmd_pkg;

    typedef enum logic [1:0] {
        WM_NONE       = 2'd0,
        WM_CNT_NOW    = 2'd1,
        WM_CNT_ATOMIC = 2'd2,
        WM_REG        = 2'd3
    } wmode_t;

    typedef enum logic [1:0] {
        RM_LIVE = 2'd0,
        RM_HELD = 2'd1,
        RM_ADC  = 2'd2,
        RM_REG  = 2'd3
    } rmode_t;

endpackage

// File: rtl/spi_cmd_link.sv
// Module: spi_cmd_link
// Synchronises the serial pins into clk and finds their edges. Counts the
// bits of each frame, assembles the received word and shifts the response
// word out. Assumes serial clock mode 0 and a serial clock at least four
// times slower than clk. SYNC_STAGES must be at least 2.
module spi_cmd_link #(
    parameter int FRAME_W     = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk,
    input  logic               cs_n,
    input  logic               mosi,
    output logic               miso,
    input  logic [FRAME_W-1:0] tx_word,
    output logic               frame_start,
    output logic               frame_end,
    output logic               frame_ok,
    output logic [FRAME_W-1:0] rx_word
);
    localparam int CNT_W = $clog2(FRAME_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

    logic [SYNC_STAGES-1:0] sclk_sync, cs_sync, mosi_sync;
    logic                   sclk_d, cs_d;
    logic                   sclk_s, cs_s, mosi_s;
    logic                   sclk_rise, sclk_fall, active;
    logic [CNT_W-1:0]       bit_cnt;
    logic [FRAME_W-1:0]     rx_q, tx_q;

    assign sclk_s = sclk_sync[SYNC_STAGES-1];
    assign cs_s   = cs_sync[SYNC_STAGES-1];
    assign mosi_s = mosi_sync[SYNC_STAGES-1];

    // Purpose: bring the three serial inputs into the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_sync <= '0;
            cs_sync   <= '1;
            mosi_sync <= '0;
        end else begin
            sclk_sync <= {sclk_sync[SYNC_STAGES-2:0], sclk};
            cs_sync   <= {cs_sync[SYNC_STAGES-2:0], cs_n};
            mosi_sync <= {mosi_sync[SYNC_STAGES-2:0], mosi};
        end
    end

    // Purpose: keep the previous synchronised levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            cs_d   <= 1'b1;
        end else begin
            sclk_d <= sclk_s;
            cs_d   <= cs_s;
        end
    end

    assign active      = ~cs_s;
    assign sclk_rise   = sclk_s & ~sclk_d;
    assign sclk_fall   = ~sclk_s & sclk_d;
    assign frame_start = cs_d & ~cs_s;
    assign frame_end   = ~cs_d & cs_s;

    // Purpose: count rising clock edges within a frame, saturating past full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
        end else if (frame_start) begin
            bit_cnt <= '0;
        end else if (active && sclk_rise && bit_cnt != CNT_SAT) begin
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // Purpose: shift received bits in, MSB first, on rising clock edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else if (active && sclk_rise) begin
            rx_q <= {rx_q[FRAME_W-2:0], mosi_s};
        end
    end

    // Purpose: load the response at frame start, advance it on falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else if (frame_start) begin
            tx_q <= tx_word;
        end else if (active && sclk_fall) begin
            tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
        end
    end

    assign frame_ok = (bit_cnt == CNT_FULL);
    assign rx_word  = rx_q;
    assign miso     = active & tx_q[FRAME_W-1];

    // The bit count does not move between frames.
    p_idle_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> $stable(bit_cnt));

    // Each falling edge in a frame brings the next lower response bit forward.
    p_shift_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (active && sclk_fall && !frame_start) |=> tx_q[FRAME_W-1] == $past(tx_q[FRAME_W-2]));

endmodule

// File: rtl/spi_cmd_regs.sv
// Module: spi_cmd_regs
// Small byte-wide register file with one write port and one combinational
// read port. Addresses at or above REGS are ignored on write and read as 0.
module spi_cmd_regs #(
    parameter int REGS = 8,
    parameter int AW   = 8,
    parameter int DW   = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int IDX_W = (REGS > 1) ? $clog2(REGS) : 1;
    localparam logic [AW:0] LIMIT = (AW + 1)'(REGS);

    logic [DW-1:0] mem [REGS];
    logic          w_in_range, r_in_range;

    assign w_in_range = ({1'b0, waddr} < LIMIT);
    assign r_in_range = ({1'b0, raddr} < LIMIT);

    for (genvar g = 0; g < REGS; g++) begin : g_reg
        // Purpose: hold one register, written when its address is selected.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[g] <= '0;
            end else if (we && w_in_range && waddr[IDX_W-1:0] == IDX_W'(g)) begin
                mem[g] <= wdata;
            end
        end
    end

    // Purpose: read the addressed register, zero when out of range.
    always_comb begin
        rdata = '0;
        if (r_in_range) begin
            rdata = mem[raddr[IDX_W-1:0]];
        end
    end

    // A write inside the range is visible in the addressed register next cycle.
    p_reg_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (we && w_in_range) |=> mem[$past(waddr[IDX_W-1:0])] == $past(wdata));

endmodule

// File: rtl/spi_cmd_exec.sv
// Module: spi_cmd_exec
// Decodes completed frames into writes. Owns the multi-cycle counter and the
// pending atomic write, and remembers the read selection. Builds the
// response snapshot that the link loads at frame start. Assumes frame_start
// and frame_end never pulse in the same cycle.
module spi_cmd_exec
    import spi_cmd_pkg::*;
#(
    parameter int FRAME_W = 32,
    parameter int MC_W    = 14,
    parameter int POS_W   = 10,
    parameter int STAT_W  = 8,
    parameter int ADC_W   = 10,
    parameter int REG_AW  = 8,
    parameter int REG_DW  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start,
    input  logic               frame_end,
    input  logic               frame_ok,
    input  logic [FRAME_W-1:0] rx_word,
    input  logic [POS_W-1:0]   pos_live,
    input  logic [STAT_W-1:0]  stat_live,
    input  logic [POS_W-1:0]   pos_held,
    input  logic [STAT_W-1:0]  stat_held,
    input  logic [ADC_W-1:0]   adc_sin,
    input  logic [ADC_W-1:0]   adc_cos,
    input  logic [ADC_W-1:0]   adc_zero,
    output logic [FRAME_W-1:0] tx_word,
    output logic               reg_we,
    output logic [REG_AW-1:0]  reg_waddr,
    output logic [REG_DW-1:0]  reg_wdata,
    output logic [REG_AW-1:0]  reg_raddr,
    input  logic [REG_DW-1:0]  reg_rdata,
    output logic [MC_W-1:0]    mc_value,
    output logic               mc_sync,
    output logic               mc_load,
    output logic               frame_err
);
    localparam int WM_LO   = FRAME_W - 2;
    localparam int RM_LO   = FRAME_W - 4;
    localparam int CRSV_LO = FRAME_W - 8;
    localparam int PAY_TOP = FRAME_W - 9;
    localparam int ADDR_LO = PAY_TOP - REG_AW + 1;

    wmode_t             cmd_wm;
    rmode_t             cmd_rm;
    logic [3:0]         ctl_rsvd;
    logic [PAY_TOP:MC_W+1] cnt_rsvd;
    logic [MC_W-1:0]    cnt_field;
    logic               sync_field;
    logic [REG_AW-1:0]  addr_field;

    logic               good, wr_allowed, cnt_allowed;
    logic               cnt_now, cnt_defer, apply_pend;

    rmode_t             rm_q;
    logic [REG_AW-1:0]  raddr_q;
    logic               pend_v, pend_sync;
    logic [MC_W-1:0]    pend_val;
    logic [MC_W-1:0]    mc_q;
    logic               sync_q, load_q, err_q;
    logic [MC_W-1:0]    mc_view;

    // Purpose: split the received word into command fields.
    always_comb begin
        cmd_wm     = wmode_t'(rx_word[FRAME_W-1:WM_LO]);
        cmd_rm     = rmode_t'(rx_word[WM_LO-1:RM_LO]);
        ctl_rsvd   = rx_word[RM_LO-1:CRSV_LO];
        cnt_rsvd   = rx_word[PAY_TOP:MC_W+1];
        cnt_field  = rx_word[MC_W:1];
        sync_field = rx_word[0];
        addr_field = rx_word[PAY_TOP:ADDR_LO];
    end

    assign good        = frame_end & frame_ok;
    assign wr_allowed  = (ctl_rsvd == '0);
    assign cnt_allowed = wr_allowed & (cnt_rsvd == '0);
    assign cnt_now     = good & cnt_allowed & (cmd_wm == WM_CNT_NOW);
    assign cnt_defer   = good & cnt_allowed & (cmd_wm == WM_CNT_ATOMIC);
    assign apply_pend  = frame_start & pend_v;

    // Purpose: drive the register file write port from a completed frame.
    always_comb begin
        reg_we    = good & wr_allowed & (cmd_wm == WM_REG);
        reg_waddr = addr_field;
        reg_wdata = rx_word[REG_DW-1:0];
        reg_raddr = raddr_q;
    end

    // Purpose: update the counter from an immediate or a pending write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mc_q   <= '0;
            sync_q <= 1'b0;
            load_q <= 1'b0;
        end else begin
            load_q <= 1'b0;
            if (apply_pend) begin
                mc_q   <= pend_val;
                sync_q <= pend_sync;
                load_q <= 1'b1;
            end else if (cnt_now) begin
                mc_q   <= cnt_field;
                sync_q <= sync_field;
                load_q <= 1'b1;
            end
        end
    end

    // Purpose: hold an atomic write until the next frame starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v    <= 1'b0;
            pend_val  <= '0;
            pend_sync <= 1'b0;
        end else if (apply_pend) begin
            pend_v <= 1'b0;
        end else if (cnt_defer) begin
            pend_v    <= 1'b1;
            pend_val  <= cnt_field;
            pend_sync <= sync_field;
        end
    end

    // Purpose: remember the read selection of the last good frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rm_q    <= RM_LIVE;
            raddr_q <= '0;
        end else if (good) begin
            rm_q    <= cmd_rm;
            raddr_q <= addr_field;
        end
    end

    // Purpose: flag frames that ended with the wrong number of bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (frame_end) begin
            err_q <= ~frame_ok;
        end
    end

    assign mc_view = apply_pend ? pend_val : mc_q;

    // Purpose: assemble the response snapshot for the selected read source.
    always_comb begin
        unique case (rm_q)
            RM_LIVE: tx_word = (FRAME_W'(mc_view) << (POS_W + STAT_W))
                             | (FRAME_W'(pos_live) << STAT_W)
                             | FRAME_W'(stat_live);
            RM_HELD: tx_word = (FRAME_W'(mc_view) << (POS_W + STAT_W))
                             | (FRAME_W'(pos_held) << STAT_W)
                             | FRAME_W'(stat_held);
            RM_ADC:  tx_word = (FRAME_W'(adc_sin)  << (FRAME_W - ADC_W))
                             | (FRAME_W'(adc_cos)  << (FRAME_W - 2 * ADC_W))
                             | (FRAME_W'(adc_zero) << (FRAME_W - 3 * ADC_W));
            default: tx_word = (FRAME_W'(raddr_q)   << (FRAME_W - REG_AW))
                             | (FRAME_W'(reg_rdata) << (FRAME_W - REG_AW - REG_DW))
                             | FRAME_W'(pos_live);
        endcase
    end

    assign mc_value  = mc_q;
    assign mc_sync   = sync_q;
    assign mc_load   = load_q;
    assign frame_err = err_q;

    // The pending value reaches the counter at the very next frame start.
    p_atomic_land_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && pend_v) |=> (mc_q == $past(pend_val)) && !pend_v && mc_load);

    // An immediate write shows up one cycle after the frame closes.
    p_now_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_now |=> (mc_q == $past(cnt_field)) && mc_load);

    // A bad-length frame changes neither the counter nor the read selection.
    p_bad_frame_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && !frame_ok) |=> $stable(mc_q) && $stable(rm_q) && frame_err);

    // Nonzero reserved bits block counter writes.
    p_rsvd_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (good && (cnt_rsvd != '0 || ctl_rsvd != '0)) |=> $stable(mc_q) && $stable(pend_v));

endmodule

// File: rtl/spi_cmd_pipe.sv
// Module: spi_cmd_pipe (top)
// Serial command decoder with a one-frame response pipeline. Joins the pin
// link, the command executor and the register file. Assumes the default
// 32-bit frame layout.
module spi_cmd_pipe #(
    parameter int FRAME_W     = 32,
    parameter int SYNC_STAGES = 2,
    parameter int MC_W        = 14,
    parameter int POS_W       = 10,
    parameter int STAT_W      = 8,
    parameter int ADC_W       = 10,
    parameter int REG_AW      = 8,
    parameter int REG_DW      = 8,
    parameter int REG_COUNT   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic [POS_W-1:0]  pos_live,
    input  logic [STAT_W-1:0] stat_live,
    input  logic [POS_W-1:0]  pos_held,
    input  logic [STAT_W-1:0] stat_held,
    input  logic [ADC_W-1:0]  adc_sin,
    input  logic [ADC_W-1:0]  adc_cos,
    input  logic [ADC_W-1:0]  adc_zero,
    output logic [MC_W-1:0]   mc_value,
    output logic              mc_sync,
    output logic              mc_load,
    output logic              frame_err
);
    logic [FRAME_W-1:0] tx_word, rx_word;
    logic               frame_start, frame_end, frame_ok;
    logic               reg_we;
    logic [REG_AW-1:0]  reg_waddr, reg_raddr;
    logic [REG_DW-1:0]  reg_wdata, reg_rdata;

    spi_cmd_link #(
        .FRAME_W     (FRAME_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_link (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk        (spi_sclk),
        .cs_n        (spi_cs_n),
        .mosi        (spi_mosi),
        .miso        (spi_miso),
        .tx_word     (tx_word),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .frame_ok    (frame_ok),
        .rx_word     (rx_word)
    );

    spi_cmd_exec #(
        .FRAME_W (FRAME_W),
        .MC_W    (MC_W),
        .POS_W   (POS_W),
        .STAT_W  (STAT_W),
        .ADC_W   (ADC_W),
        .REG_AW  (REG_AW),
        .REG_DW  (REG_DW)
    ) u_exec (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .frame_ok    (frame_ok),
        .rx_word     (rx_word),
        .pos_live    (pos_live),
        .stat_live   (stat_live),
        .pos_held    (pos_held),
        .stat_held   (stat_held),
        .adc_sin     (adc_sin),
        .adc_cos     (adc_cos),
        .adc_zero    (adc_zero),
        .tx_word     (tx_word),
        .reg_we      (reg_we),
        .reg_waddr   (reg_waddr),
        .reg_wdata   (reg_wdata),
        .reg_raddr   (reg_raddr),
        .reg_rdata   (reg_rdata),
        .mc_value    (mc_value),
        .mc_sync     (mc_sync),
        .mc_load     (mc_load),
        .frame_err   (frame_err)
    );

    spi_cmd_regs #(
        .REGS (REG_COUNT),
        .AW   (REG_AW),
        .DW   (REG_DW)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .waddr (reg_waddr),
        .wdata (reg_wdata),
        .raddr (reg_raddr),
        .rdata (reg_rdata)
    );

endmodule

// File: tb/spi_cmd_pipe_test.sv
// Directed bench: one task per scenario, each checking its own results.
module spi_cmd_pipe_test;
    localparam int CLK_PERIOD = 10;
    localparam int SCK_HALF   = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic        miso;
    logic [9:0]  pos_live = '0, pos_held = '0;
    logic [7:0]  stat_live = '0, stat_held = '0;
    logic [9:0]  adc_sin = '0, adc_cos = '0, adc_zero = '0;
    logic [13:0] mc_value;
    logic        mc_sync, mc_load, frame_err;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    spi_cmd_pipe uut (
        .clk (clk), .rst_n (rst_n),
        .spi_sclk (sclk), .spi_cs_n (cs_n), .spi_mosi (mosi), .spi_miso (miso),
        .pos_live (pos_live), .stat_live (stat_live),
        .pos_held (pos_held), .stat_held (stat_held),
        .adc_sin (adc_sin), .adc_cos (adc_cos), .adc_zero (adc_zero),
        .mc_value (mc_value), .mc_sync (mc_sync), .mc_load (mc_load),
        .frame_err (frame_err)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [1:0] wm, input logic [1:0] rm,
                                       input logic [3:0] rs, input logic [23:0] pay);
        return {wm, rm, rs, pay};
    endfunction

    function automatic logic [23:0] cnt_pay(input logic [8:0] rsv, input logic [13:0] v,
                                            input logic s);
        return {rsv, v, s};
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Sends nbits of cmd MSB first (zeros past bit 31), collecting miso.
    task automatic send(input logic [31:0] cmd, input int nbits, output logic [31:0] resp);
        resp = '0;
        cs_n = 1'b0;
        wait_clk(8);
        for (int i = 0; i < nbits; i++) begin
            mosi = (i < 32) ? cmd[31 - i] : 1'b0;
            wait_clk(SCK_HALF);
            resp = {resp[30:0], miso};
            sclk = 1'b1;
            wait_clk(SCK_HALF);
            sclk = 1'b0;
        end
        wait_clk(SCK_HALF);
        cs_n = 1'b1;
        wait_clk(12);
    endtask

    task automatic t_reset;
        check(miso == 1'b0, "R12 miso", 32'(miso), 0);
        check(mc_value == 14'd0, "R12 counter", 32'(mc_value), 0);
        check({mc_sync, mc_load, frame_err} == 3'b000, "R12 flags",
              32'({mc_sync, mc_load, frame_err}), 0);
    endtask

    task automatic t_pipeline;
        logic [31:0] r;
        pos_live = 10'h2A5; stat_live = 8'hC3;
        adc_sin = 10'h111; adc_cos = 10'h222; adc_zero = 10'h333;
        send(mk(2'd0, 2'd2, 4'h0, 24'h0), 32, r);
        // R12: reset selection is mode 0 (live).
        check(r == {14'd0, 10'h2A5, 8'hC3}, "R12 initial selection", r, {14'd0, 10'h2A5, 8'hC3});
        send(mk(2'd0, 2'd0, 4'h0, 24'hFFFFFF), 32, r);
        // R2: this frame carries the ADC response asked for one frame earlier.
        check(r == {10'h111, 10'h222, 10'h333, 2'b00}, "R2 R5 trailing response", r,
              {10'h111, 10'h222, 10'h333, 2'b00});
        check(mc_value == 14'd0, "R10 null write leaves counter", 32'(mc_value), 0);
        send(mk(2'd0, 2'd0, 4'h0, 24'h0), 32, r);
        check(r == {14'd0, 10'h2A5, 8'hC3}, "R1 R3 live read", r, {14'd0, 10'h2A5, 8'hC3});
        check(miso == 1'b0, "R2 miso idle", 32'(miso), 0);
    endtask

    task automatic t_now_write;
        logic [31:0] r;
        send(mk(2'd1, 2'd0, 4'h0, cnt_pay(9'd0, 14'h1ABC, 1'b1)), 32, r);
        check(mc_value == 14'h1ABC, "R7 immediate load", 32'(mc_value), 32'h1ABC);
        check(mc_sync == 1'b1, "R7 sync flag", 32'(mc_sync), 1);
        send(mk(2'd0, 2'd0, 4'h0, 24'h0), 32, r);
        check(r == {14'h1ABC, 10'h2A5, 8'hC3}, "R3 counter in response", r,
              {14'h1ABC, 10'h2A5, 8'hC3});
    endtask

    task automatic t_atomic;
        logic [31:0] r;
        send(mk(2'd2, 2'd0, 4'h0, cnt_pay(9'd0, 14'h0555, 1'b0)), 32, r);
        check(mc_value == 14'h1ABC, "R8 held at frame end", 32'(mc_value), 32'h1ABC);
        pos_live = 10'h0F0;
        send(mk(2'd0, 2'd0, 4'h0, 24'h0), 32, r);
        check(r == {14'h0555, 10'h0F0, 8'hC3}, "R8 snapshot shows new count", r,
              {14'h0555, 10'h0F0, 8'hC3});
        check(mc_value == 14'h0555 && mc_sync == 1'b0, "R8 loaded at next start",
              32'({mc_sync, mc_value}), 32'h0555);
    endtask

    task automatic t_reserved;
        logic [31:0] r;
        send(mk(2'd1, 2'd0, 4'h0, cnt_pay(9'h100, 14'h3FFF, 1'b1)), 32, r);
        check(mc_value == 14'h0555, "R9 payload reserved blocks write", 32'(mc_value), 32'h0555);
        send(mk(2'd2, 2'd0, 4'h0, cnt_pay(9'h001, 14'h2222, 1'b1)), 32, r);
        send(mk(2'd0, 2'd0, 4'h0, 24'h0), 32, r);
        check(mc_value == 14'h0555, "R9 reserved blocks atomic", 32'(mc_value), 32'h0555);
        send(mk(2'd1, 2'd0, 4'h8, cnt_pay(9'd0, 14'h0777, 1'b0)), 32, r);
        check(mc_value == 14'h0555, "R9 control reserved blocks write", 32'(mc_value), 32'h0555);
    endtask

    task automatic t_registers;
        logic [31:0] r;
        send(mk(2'd3, 2'd3, 4'h0, {8'h03, 8'h00, 8'h5A}), 32, r);
        send(mk(2'd0, 2'd3, 4'h0, {8'h20, 16'h0}), 32, r);
        check(r == {8'h03, 8'h5A, 6'd0, 10'h0F0}, "R6 R10 register read back", r,
              {8'h03, 8'h5A, 6'd0, 10'h0F0});
        send(mk(2'd0, 2'd0, 4'h0, 24'h0), 32, r);
        check(r == {8'h20, 8'h00, 6'd0, 10'h0F0}, "R6 out of range reads zero", r,
              {8'h20, 8'h00, 6'd0, 10'h0F0});
    endtask

    task automatic t_held;
        logic [31:0] r;
        pos_held = 10'h3A1; stat_held = 8'h6E;
        send(mk(2'd0, 2'd1, 4'h0, 24'h0), 32, r);
        send(mk(2'd0, 2'd0, 4'h0, 24'h0), 32, r);
        check(r == {14'h0555, 10'h3A1, 8'h6E}, "R4 held read", r, {14'h0555, 10'h3A1, 8'h6E});
    endtask

    task automatic t_bad_length;
        logic [31:0] r;
        adc_sin = 10'h0AB; adc_cos = 10'h1CD; adc_zero = 10'h2EF;
        send(mk(2'd0, 2'd2, 4'h0, 24'h0), 32, r);
        send(mk(2'd1, 2'd0, 4'h0, cnt_pay(9'd0, 14'h0123, 1'b1)), 20, r);
        check(frame_err == 1'b1, "R11 short frame flagged", 32'(frame_err), 1);
        check(mc_value == 14'h0555, "R11 short frame no write", 32'(mc_value), 32'h0555);
        send(mk(2'd0, 2'd0, 4'h0, 24'h0), 32, r);
        check(r == {10'h0AB, 10'h1CD, 10'h2EF, 2'b00}, "R11 selection kept", r,
              {10'h0AB, 10'h1CD, 10'h2EF, 2'b00});
        check(frame_err == 1'b0, "R11 good frame clears flag", 32'(frame_err), 0);
        send(mk(2'd1, 2'd0, 4'h0, cnt_pay(9'd0, 14'h0321, 1'b1)), 33, r);
        check(frame_err == 1'b1 && mc_value == 14'h0555, "R11 long frame discarded",
              32'({frame_err, mc_value}), 32'h4555);
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        t_reset();
        t_pipeline();
        t_now_write();
        t_atomic();
        t_reserved();
        t_registers();
        t_held();
        t_bad_length();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule